// File: doc/BRIEF.md
# PC Sampling Debug Register Slave

This block is a bank of memory-mapped debug registers behind an APB-style slave port. An outside agent uses it to take samples of a running core's program counter and execution context without stopping the core. The core side supplies a live 64-bit PC, a context identifier, a virtualization/state word and a flag that is high when the core is halted in debug state or profiling is prohibited.

Reading the PC-sample-low register returns the low half of the live PC. On the same clock edge, the context-ID, virtualization-context and PC-high registers load from the core inputs. Later reads of those three return that coherent snapshot, so the two PC halves never mix values from different moments. When sampling is not allowed, the PC-low read returns all ones. Two read-only identity registers report which sample registers are built and which PC offset policy applies. A lock register and a lock-status register give a simple OS lock.

The port logic is a three-state machine: `ST_IDLE`, `ST_RD_ACC` (read access phase) and `ST_WR_ACC` (write access phase). `ST_IDLE` moves to `ST_RD_ACC` or `ST_WR_ACC` on a setup phase (select high, enable low), which chooses the read or write path. Both access states return to `ST_IDLE` after one cycle. Read data, the error flag and any capture are all settled on the setup edge.

Top module: `pcs_dbg_slave`

## Requirements
- R1: After reset, `prdata` is 0, `pready` and `pslverr` are low, and the OS lock is set, so the lock-status register at 0x304 reads 1 in bit 0.
- R2: Every transfer gets one access cycle with no wait states. `pready` is high in the cycle after the setup cycle and low in all other cycles.
- R3: A read of PC-low at 0x0A0 that is allowed to sample returns `core_pc[31:0]`. On the same edge it loads the context-ID (0x0A4), virtualization-context (0x0A8) and PC-high (0x0AC) registers from `core_ctxid`, `core_vctx` and `core_pc[63:32]`.
- R4: When `core_halted` is high, a PC-low read returns 0xFFFFFFFF and the three companion registers keep their previous contents.
- R5: With `OFFSET_POLICY` = 2, sampling is also refused when `core_vctx` bit 28 (64-bit width) is 0, and the PC-low read returns 0xFFFFFFFF.
- R6: Reads of the context-ID, virtualization-context and PC-high registers have no side effect. A change of the core PC after a PC-low read does not alter a later PC-high read, so the 64-bit sample never tears.
- R7: The identity register at 0xFC8 returns `IMPL_MODE` in bits 3:0 (1 = PC only, 2 = PC and context ID, 3 = PC, context ID and virtualization context). The register at 0xFC4 returns `OFFSET_POLICY` in bits 3:0 (0 = offset by instruction state, 1 = no offset, 2 = no offset and invalid in 32-bit state). All upper bits read as zero.
- R8: A companion register that `IMPL_MODE` leaves out reads as zero without an error: context ID when `IMPL_MODE` < 2, virtualization context when `IMPL_MODE` < 3.
- R9: A write to the OS-lock register at 0x300 with bit 0 = 0 clears the lock, and a write with bit 0 = 1 sets it. The lock-status register at 0x304 shows the lock in bit 0. The lock register itself reads as zero.
- R10: An access to any offset outside the map raises `pslverr` in its access cycle and reads zero. Mapped offsets never raise it.
- R11: Writes to the sample and identity registers are ignored and give no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase enable |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while pready is high |
| pready | output | 1 | Access-phase completion, never stretched |
| pslverr | output | 1 | Error for unmapped offsets |
| core_pc | input | 64 | Live program counter |
| core_ctxid | input | 32 | Live context identifier |
| core_vctx | input | 32 | Live state word: bit 31 non-secure, 30 EL2, 29 EL3, 28 64-bit, 7:0 VMID |
| core_halted | input | 1 | Core halted in debug state or profiling prohibited |

## Verification
A snapshot register that loads on the wrong edge, or on a read other than PC-low, shows up on the first later read of PC-high, context ID or virtualization context after the core inputs have moved. Random core values make such a fault visible within one read sequence. A wrong state in the port machine shows at once as `pready` in the wrong cycle or as stale read data. A decode fault shows as `pslverr` or a wrong value on the next access to the affected offset. The OS-lock state can only be seen through the status register, so a lost or wrong lock update shows on the next status read.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    localparam logic [11:0] OFS_PC_LO   = 12'h0A0;
    localparam logic [11:0] OFS_CTXID   = 12'h0A4;
    localparam logic [11:0] OFS_VCTX    = 12'h0A8;
    localparam logic [11:0] OFS_PC_HI   = 12'h0AC;
    localparam logic [11:0] OFS_OSLOCK  = 12'h300;
    localparam logic [11:0] OFS_LKSTAT  = 12'h304;
    localparam logic [11:0] OFS_IDENT1  = 12'hFC4;
    localparam logic [11:0] OFS_IDENT0  = 12'hFC8;

    localparam logic [31:0] SAMPLE_REFUSED = 32'hFFFF_FFFF;
    localparam int          VCTX_WIDE_BIT  = 28;

    typedef enum logic [3:0] {
        SEL_PC_LO,
        SEL_CTXID,
        SEL_VCTX,
        SEL_PC_HI,
        SEL_OSLOCK,
        SEL_LKSTAT,
        SEL_IDENT0,
        SEL_IDENT1,
        SEL_NONE
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_WR_ACC
    } apb_state_e;

endpackage

// File: rtl/pcs_addr_decode.sv
module pcs_addr_decode
    import pcs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic              hit
);

    localparam int CMP_W = (ADDR_W < 12) ? ADDR_W : 12;

    logic upper_zero;
    logic [11:0] low_ofs;

    generate
        if (ADDR_W > 12) begin : g_wide
            assign upper_zero = (addr[ADDR_W-1:12] == '0);
            assign low_ofs    = addr[11:0];
        end else begin : g_narrow
            assign upper_zero = 1'b1;
            assign low_ofs    = 12'(addr[CMP_W-1:0]);
        end
    endgenerate

    always_comb begin
        sel = SEL_NONE;
        if (upper_zero) begin
            unique case (low_ofs)
                OFS_PC_LO:  sel = SEL_PC_LO;
                OFS_CTXID:  sel = SEL_CTXID;
                OFS_VCTX:   sel = SEL_VCTX;
                OFS_PC_HI:  sel = SEL_PC_HI;
                OFS_OSLOCK: sel = SEL_OSLOCK;
                OFS_LKSTAT: sel = SEL_LKSTAT;
                OFS_IDENT0: sel = SEL_IDENT0;
                OFS_IDENT1: sel = SEL_IDENT1;
                default:    sel = SEL_NONE;
            endcase
        end
    end

    assign hit = (sel != SEL_NONE);

endmodule

// File: rtl/pcs_apb_fsm.sv
module pcs_apb_fsm
    import pcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       psel,
    input  logic       penable,
    input  logic       pwrite,
    output apb_state_e state,
    output logic       setup_fire,
    output logic       wr_commit,
    output logic       pready
);

    apb_state_e state_d;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (psel && !penable)
                    state_d = pwrite ? ST_WR_ACC : ST_RD_ACC;
            end
            ST_RD_ACC: state_d = ST_IDLE;
            ST_WR_ACC: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    always_comb begin
        setup_fire = 1'b0;
        wr_commit  = 1'b0;
        pready     = 1'b0;
        unique case (state)
            ST_IDLE:   setup_fire = psel && !penable;
            ST_RD_ACC: pready = 1'b1;
            ST_WR_ACC: begin
                pready    = 1'b1;
                wr_commit = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pcs_sample_bank.sv
module pcs_sample_bank
    import pcs_pkg::*;
#(
    parameter int IMPL_MODE     = 3,
    parameter int OFFSET_POLICY = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        capture_req,
    input  logic [63:0] core_pc,
    input  logic [31:0] core_ctxid,
    input  logic [31:0] core_vctx,
    input  logic        core_halted,
    output logic [31:0] pc_lo_view,
    output logic [31:0] snap_ctxid,
    output logic [31:0] snap_vctx,
    output logic [31:0] snap_pchi
);

    logic refuse;
    logic load;

    generate
        if (OFFSET_POLICY == 2) begin : g_narrow_refuse
            assign refuse = core_halted || !core_vctx[VCTX_WIDE_BIT];
        end else begin : g_plain_refuse
            assign refuse = core_halted;
        end
    endgenerate

    assign load       = capture_req && !refuse;
    assign pc_lo_view = refuse ? SAMPLE_REFUSED : core_pc[31:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    snap_pchi <= '0;
        else if (load) snap_pchi <= core_pc[63:32];
    end

    generate
        if (IMPL_MODE >= 2) begin : g_ctxid
            logic [31:0] ctxid_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    ctxid_q <= '0;
                else if (load) ctxid_q <= core_ctxid;
            end
            assign snap_ctxid = ctxid_q;
        end else begin : g_no_ctxid
            assign snap_ctxid = '0;
        end

        if (IMPL_MODE >= 3) begin : g_vctx
            logic [31:0] vctx_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    vctx_q <= '0;
                else if (load) vctx_q <= core_vctx;
            end
            assign snap_vctx = vctx_q;
        end else begin : g_no_vctx
            assign snap_vctx = '0;
        end
    endgenerate

endmodule

// File: rtl/pcs_dbg_slave.sv
module pcs_dbg_slave
    import pcs_pkg::*;
#(
    parameter int ADDR_W        = 12,
    parameter int IMPL_MODE     = 3,
    parameter int OFFSET_POLICY = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic [63:0]       core_pc,
    input  logic [31:0]       core_ctxid,
    input  logic [31:0]       core_vctx,
    input  logic              core_halted
);

    localparam logic [31:0] IDENT0_VAL = 32'(IMPL_MODE & 4'hF);
    localparam logic [31:0] IDENT1_VAL = 32'(OFFSET_POLICY & 4'hF);

    apb_state_e  state;
    logic        setup_fire;
    logic        wr_commit;
    reg_sel_e    sel;
    logic        hit;
    logic [31:0] pc_lo_view;
    logic [31:0] snap_ctxid;
    logic [31:0] snap_vctx;
    logic [31:0] snap_pchi;
    logic [31:0] rd_val;
    logic [31:0] prdata_q;
    logic        pslverr_q;
    reg_sel_e    wr_sel_q;
    logic        wr_bit_q;
    logic        os_lock_q;

    pcs_apb_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .psel       (psel),
        .penable    (penable),
        .pwrite     (pwrite),
        .state      (state),
        .setup_fire (setup_fire),
        .wr_commit  (wr_commit),
        .pready     (pready)
    );

    pcs_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (paddr),
        .sel  (sel),
        .hit  (hit)
    );

    pcs_sample_bank #(
        .IMPL_MODE     (IMPL_MODE),
        .OFFSET_POLICY (OFFSET_POLICY)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture_req (setup_fire && !pwrite && (sel == SEL_PC_LO)),
        .core_pc     (core_pc),
        .core_ctxid  (core_ctxid),
        .core_vctx   (core_vctx),
        .core_halted (core_halted),
        .pc_lo_view  (pc_lo_view),
        .snap_ctxid  (snap_ctxid),
        .snap_vctx   (snap_vctx),
        .snap_pchi   (snap_pchi)
    );

    always_comb begin
        rd_val = '0;
        unique case (sel)
            SEL_PC_LO:  rd_val = pc_lo_view;
            SEL_CTXID:  rd_val = snap_ctxid;
            SEL_VCTX:   rd_val = snap_vctx;
            SEL_PC_HI:  rd_val = snap_pchi;
            SEL_OSLOCK: rd_val = '0;
            SEL_LKSTAT: rd_val = {31'd0, os_lock_q};
            SEL_IDENT0: rd_val = IDENT0_VAL;
            SEL_IDENT1: rd_val = IDENT1_VAL;
            default:    rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prdata_q  <= '0;
            pslverr_q <= 1'b0;
            wr_sel_q  <= SEL_NONE;
            wr_bit_q  <= 1'b0;
        end else if (setup_fire) begin
            prdata_q  <= (!pwrite && hit) ? rd_val : '0;
            pslverr_q <= !hit;
            wr_sel_q  <= pwrite ? sel : SEL_NONE;
            wr_bit_q  <= pwdata[0];
        end else if (state != ST_IDLE) begin
            prdata_q  <= '0;
            pslverr_q <= 1'b0;
            wr_sel_q  <= SEL_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            os_lock_q <= 1'b1;
        else if (wr_commit && (wr_sel_q == SEL_OSLOCK))
            os_lock_q <= wr_bit_q;
    end

    assign prdata  = prdata_q;
    assign pslverr = pslverr_q;

endmodule

// File: rtl/pcs_dbg_checker.sv
module pcs_dbg_checker #(
    parameter int ADDR_W        = 12,
    parameter int OFFSET_POLICY = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [31:0]       pwdata,
    input logic [31:0]       prdata,
    input logic              pready,
    input logic              pslverr,
    input logic [63:0]       core_pc,
    input logic [31:0]       core_vctx,
    input logic              core_halted,
    input logic [31:0]       snap_pchi,
    input logic              os_lock_q
);

    logic setup_rd_lo;
    logic allowed;
    assign setup_rd_lo = psel && !penable && !pwrite && (paddr == ADDR_W'(12'h0A0));
    assign allowed     = !core_halted && ((OFFSET_POLICY != 2) || core_vctx[28]);

    // R2
    ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pready |=> !pready);

    // R2
    ready_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !penable && !pready) |=> pready);

    // R4
    refused_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(setup_rd_lo && core_halted) |-> (prdata == 32'hFFFF_FFFF));

    // R3
    pchi_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(setup_rd_lo && allowed) |-> (snap_pchi == $past(core_pc[63:32])));

    // R6
    pchi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(setup_rd_lo) |-> $stable(snap_pchi));

    // R9
    oslock_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(psel && penable && pwrite && pready && (paddr == ADDR_W'(12'h300)))
        |-> (os_lock_q == $past(pwdata[0])));

    // R10
    err_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> pready);

endmodule

bind pcs_dbg_slave pcs_dbg_checker #(
    .ADDR_W        (ADDR_W),
    .OFFSET_POLICY (OFFSET_POLICY)
) u_pcs_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .psel        (psel),
    .penable     (penable),
    .pwrite      (pwrite),
    .paddr       (paddr),
    .pwdata      (pwdata),
    .prdata      (prdata),
    .pready      (pready),
    .pslverr     (pslverr),
    .core_pc     (core_pc),
    .core_vctx   (core_vctx),
    .core_halted (core_halted),
    .snap_pchi   (snap_pchi),
    .os_lock_q   (os_lock_q)
);

// File: tb/test_pcs_dbg_slave.sv
`timescale 1ns/1ps
module test_pcs_dbg_slave;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [63:0] core_pc = '0;
    logic [31:0] core_ctxid = '0, core_vctx = '0;
    logic        core_halted = 1'b0;
    logic [31:0] prdata, prdata_l;
    logic        pready, pready_l, pslverr, pslverr_l;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pcs_dbg_slave i_pcs_dbg_slave (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .core_pc(core_pc), .core_ctxid(core_ctxid),
        .core_vctx(core_vctx), .core_halted(core_halted));

    pcs_dbg_slave #(.IMPL_MODE(1), .OFFSET_POLICY(2)) i_pcs_dbg_slave_lite (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata_l), .pready(pready_l),
        .pslverr(pslverr_l), .core_pc(core_pc), .core_ctxid(core_ctxid),
        .core_vctx(core_vctx), .core_halted(core_halted));

    function automatic logic [31:0] exp_lo(input logic [63:0] pc, input logic halted,
                                           input logic [31:0] vctx, input int policy);
        if (halted || (policy == 2 && !vctx[28])) return 32'hFFFF_FFFF;
        return pc[31:0];
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] expv);
        n_cmp++;
        if (got !== expv) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", req, got, expv);
        end
    endtask

    task automatic xfer(input logic wr, input logic [11:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic [31:0] rd_l,
                        output logic err, output logic rdy);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1;
        #1;
        rd = prdata; rd_l = prdata_l; err = pslverr; rdy = pready;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd_main(input logic [11:0] a, output logic [31:0] v);
        logic [31:0] l; logic e, r;
        xfer(1'b0, a, 32'd0, v, l, e, r);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, vl;
        logic e, r;
        logic [63:0] s_pc;
        logic [31:0] s_cid, s_vctx;
        void'($urandom(32'h1A2B3C4D));

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 prdata", prdata, 32'd0);
        chk("R1 pready", {31'd0, pready}, 32'd0);
        chk("R1 pslverr", {31'd0, pslverr}, 32'd0);
        rst_n = 1;
        @(negedge clk);
        xfer(1'b0, 12'h304, 0, v, vl, e, r);
        chk("R1 lock status", v, 32'd1);
        chk("R2 pready in access", {31'd0, r}, 32'd1);
        chk("R2 pready after access", {31'd0, pready}, 32'd0);

        // R7 identity
        rd_main(12'hFC8, v); chk("R7 ident0", v, 32'd3);
        xfer(1'b0, 12'hFC4, 0, v, vl, e, r);
        chk("R7 ident1", v, 32'd0);
        chk("R7 ident1 lite", vl, 32'd2);
        xfer(1'b0, 12'hFC8, 0, v, vl, e, r);
        chk("R7 ident0 lite", vl, 32'd1);

        // R9 os lock
        xfer(1'b1, 12'h300, 32'd0, v, vl, e, r);
        chk("R9 write no err", {31'd0, e}, 32'd0);
        rd_main(12'h304, v); chk("R9 cleared", v, 32'd0);
        rd_main(12'h300, v); chk("R9 lock reg reads zero", v, 32'd0);
        xfer(1'b1, 12'h300, 32'd1, v, vl, e, r);
        rd_main(12'h304, v); chk("R9 set", v, 32'd1);

        // R10 unmapped
        xfer(1'b0, 12'h0B0, 0, v, vl, e, r);
        chk("R10 err", {31'd0, e}, 32'd1);
        chk("R10 data zero", v, 32'd0);
        xfer(1'b1, 12'h123, 32'hFFFF, v, vl, e, r);
        chk("R10 write err", {31'd0, e}, 32'd1);
        xfer(1'b0, 12'h0A4, 0, v, vl, e, r);
        chk("R10 mapped no err", {31'd0, e}, 32'd0);

        // R3 / R6 directed tear check
        core_pc = 64'h1111_2222_3333_4444; core_ctxid = 32'hC1D0; core_vctx = 32'h9000_0042;
        core_halted = 0;
        xfer(1'b0, 12'h0A0, 0, v, vl, e, r);
        chk("R3 pc lo", v, 32'h3333_4444);
        chk("R5 lite narrow ok", vl, 32'h3333_4444);
        core_pc = 64'hAAAA_BBBB_CCCC_DDDD;
        xfer(1'b0, 12'h0AC, 0, v, vl, e, r);
        chk("R6 no tear pc hi", v, 32'h1111_2222);
        chk("R8 lite pc hi", vl, 32'h1111_2222);
        rd_main(12'h0AC, v); chk("R6 repeat pc hi", v, 32'h1111_2222);

        // R5 narrow state refused on lite, allowed on main
        core_vctx = 32'h0000_0007;
        xfer(1'b0, 12'h0A0, 0, v, vl, e, r);
        chk("R5 main allowed", v, 32'hCCCC_DDDD);
        chk("R5 lite refused", vl, 32'hFFFF_FFFF);
        xfer(1'b0, 12'h0A4, 0, v, vl, e, r);
        chk("R8 lite ctxid zero", vl, 32'd0);
        xfer(1'b0, 12'h0A8, 0, v, vl, e, r);
        chk("R8 lite vctx zero", vl, 32'd0);
        chk("R3 main vctx", v, 32'h0000_0007);

        // R11 writes ignored
        xfer(1'b1, 12'h0AC, 32'h5555_5555, v, vl, e, r);
        chk("R11 no err", {31'd0, e}, 32'd0);
        rd_main(12'h0AC, v); chk("R11 pc hi kept", v, 32'hAAAA_BBBB);
        xfer(1'b1, 12'hFC8, 32'h0, v, vl, e, r);
        rd_main(12'hFC8, v); chk("R11 ident kept", v, 32'd3);

        // R4 refused read keeps previous snapshot
        s_pc = core_pc; s_cid = core_ctxid; s_vctx = core_vctx;
        core_halted = 1; core_pc = 64'h0;
        rd_main(12'h0A0, v); chk("R4 halted ones", v, 32'hFFFF_FFFF);
        core_halted = 0;

        // random mix
        for (int i = 0; i < 60; i++) begin
            logic h;
            core_pc = {$urandom(), $urandom()};
            core_ctxid = $urandom();
            core_vctx = $urandom();
            h = ($urandom() % 4) == 0;
            core_halted = h;
            xfer(1'b0, 12'h0A0, 0, v, vl, e, r);
            chk("R3/R4 random pc lo", v, exp_lo(core_pc, h, core_vctx, 0));
            chk("R5 random lite pc lo", vl, exp_lo(core_pc, h, core_vctx, 2));
            if (!h) begin
                s_pc = core_pc; s_cid = core_ctxid; s_vctx = core_vctx;
            end
            core_pc = {$urandom(), $urandom()};
            core_ctxid = $urandom();
            core_vctx = $urandom();
            core_halted = 0;
            if (!h) begin
                rd_main(12'h0A4, v); chk("R6 random ctxid", v, s_cid);
                rd_main(12'h0A8, v); chk("R6 random vctx", v, s_vctx);
                rd_main(12'h0AC, v); chk("R6 random pc hi", v, s_pc[63:32]);
            end
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule